// File: doc/BRIEF.md
# Page access rights and fault encoder

This combinational unit sits after a page-table walker. The walker supplies the user, writable and no-execute rights it has merged along the walk, the leaf entry, and any not-present or reserved-bit condition it found. The unit then decides which of read, write and execute the page allows for the current access.

The decision depends on the privilege of the access and on several mode enables: write protection for supervisor writes, supervisor execute prevention, supervisor access prevention and no-execute. It also applies per-key access-disable and write-disable bits. These come from one of two key-rights registers, one for user pages and one for supervisor pages.

The unit reports whether the requested access faults and builds the page-fault error code. That code also covers the causes the walker reported. Nothing is registered, so the outputs follow the inputs in the same cycle.

Top module: `page_rights_check`

## Requirements
- R1: A walker fault takes precedence over every other cause, and on a walker fault `grant` is 000 and `fault` is 1. If `walk_np` is set, the error code starts from zero. If only `walk_rsvd` is set, it starts with the reserved bit (bit 3) set. If both are set, `walk_np` wins.
- R2: A user access (`user_mode`=1) to a page whose merged user bit `rt_user` is 0 faults. The error code starts with P (bit 0), and `grant` is 000.
- R3: Read (grant bit 0) is granted unless the access is supervisor-mode, `en_smap` is set and `rt_user` is 1.
- R4: Write (grant bit 1) needs read to be granted under R3. It also needs either `rt_rw`=1, or a supervisor access with `en_wp`=0.
- R5: Execute (grant bit 2) is granted when `rt_nx` is 0. The one exception is a supervisor access to a user page while `en_smep` is set.
- R6: The key k is `leaf_entry[62:59]`. User pages use `ukey_rights`, and only if `en_pke` is set. Supervisor pages use `skey_rights`, and only if `en_pks` is set. Bit 2k of the selected register removes read and write. Bit 2k+1 removes write only for user accesses or when `en_wp` is set. Keys never affect execute.
- R7: `acc_kind` selects the access: 2'b00 load, 2'b01 store, 2'b10 fetch, and 2'b11 is treated as a load. A load needs read, a store needs write and a fetch needs execute. A missing right is a fault. If the key rights alone deny the requested access, the code starts with PK (bit 5) and P (bit 0). Any other denial starts with P only.
- R8: On any fault, the error code adds U (bit 2) for a user access and W (bit 1) for a store. It adds I/D (bit 4) for a fetch only when `en_nxe` or `en_smep` is set. When there is no fault, `err_code` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_kind | input | 2 | Access kind: load, store, fetch |
| user_mode | input | 1 | Access made at user privilege |
| walk_np | input | 1 | Walker found a not-present entry |
| walk_rsvd | input | 1 | Walker found a reserved bit set |
| rt_user | input | 1 | Merged user-page right |
| rt_rw | input | 1 | Merged writable right |
| rt_nx | input | 1 | Merged no-execute flag |
| leaf_entry | input | 64 | Leaf page-table entry |
| en_wp | input | 1 | Supervisor write protection enable |
| en_smep | input | 1 | Supervisor execute prevention enable |
| en_smap | input | 1 | Supervisor access prevention in effect |
| en_nxe | input | 1 | No-execute enable |
| en_pke | input | 1 | User key checking enable |
| en_pks | input | 1 | Supervisor key checking enable |
| ukey_rights | input | 32 | User key rights, two bits per key |
| skey_rights | input | 32 | Supervisor key rights, two bits per key |
| grant | output | 3 | Granted rights {exec, write, read} |
| fault | output | 1 | Requested access faults |
| err_code | output | 6 | Page-fault error code |

## Verification
The sweep covers every combination of the access kind, privilege, merged rights, walker causes and mode enables. For each vector it also picks a key and sets both of that key's bits in each register. All other key slots are filled with the opposite pattern, so a design that indexed the wrong slot, or read the other register, would grant or deny the wrong rights.

Three cases are targeted directly. A design that let a key stop a fetch would flag PK on instruction fetches. A design that set I/D regardless of the mode enables would report fetch faults with bit 4 on when neither enable is set. A design that ignored write protection in the key write-disable rule would deny supervisor writes that should pass. The bench also checks that a not-present fault wins over a reserved-bit fault when both are raised.

// File: rtl/page_rights_check.sv
module page_rights_check #(
  parameter int KEY_LSB = 59,
  parameter int KEY_W   = 4
) (
  input  logic [1:0]  acc_kind,
  input  logic        user_mode,
  input  logic        walk_np,
  input  logic        walk_rsvd,
  input  logic        rt_user,
  input  logic        rt_rw,
  input  logic        rt_nx,
  input  logic [63:0] leaf_entry,
  input  logic        en_wp,
  input  logic        en_smep,
  input  logic        en_smap,
  input  logic        en_nxe,
  input  logic        en_pke,
  input  logic        en_pks,
  input  logic [(2<<KEY_W)-1:0] ukey_rights,
  input  logic [(2<<KEY_W)-1:0] skey_rights,
  output logic [2:0]  grant,
  output logic        fault,
  output logic [5:0]  err_code
);
  localparam int KREG_W = 2 << KEY_W;
  localparam int EB_P    = 0;
  localparam int EB_W    = 1;
  localparam int EB_U    = 2;
  localparam int EB_RSVD = 3;
  localparam int EB_ID   = 4;
  localparam int EB_PK   = 5;

  logic req_r, req_w, req_x;
  assign req_w = (acc_kind == 2'b01);
  assign req_x = (acc_kind == 2'b10);
  assign req_r = !req_w && !req_x;

  logic walk_bad, u_viol;
  assign walk_bad = walk_np | walk_rsvd;
  assign u_viol   = user_mode & ~rt_user;

  logic smap_hit, base_r, base_w, base_x;
  assign smap_hit = en_smap & ~user_mode & rt_user;
  assign base_r   = ~smap_hit;
  assign base_w   = base_r & (rt_rw | (~user_mode & ~en_wp));
  assign base_x   = ~rt_nx & (user_mode | ~(en_smep & rt_user));

  logic [KEY_W-1:0]  key_idx;
  logic [KREG_W-1:0] key_reg;
  logic              key_ad, key_wd, km_r, km_w;
  assign key_idx = leaf_entry[KEY_LSB +: KEY_W];
  assign key_reg = rt_user ? (en_pke ? ukey_rights : '0)
                           : (en_pks ? skey_rights : '0);
  assign key_ad  = key_reg[{key_idx, 1'b0}];
  assign key_wd  = key_reg[{key_idx, 1'b1}];
  assign km_r    = ~key_ad;
  assign km_w    = ~key_ad & ~(key_wd & (user_mode | en_wp));

  logic [2:0] rights;
  assign rights = (walk_bad | u_viol) ? 3'b000
                : {base_x, base_w & km_w, base_r & km_r};

  logic key_deny, rights_deny;
  assign key_deny    = (req_r & ~km_r) | (req_w & ~km_w);
  assign rights_deny = (req_r & ~rights[0]) | (req_w & ~rights[1]) | (req_x & ~rights[2]);

  logic [5:0] cause, mods;
  always_comb begin
    cause = '0;
    if (walk_np)        cause = '0;
    else if (walk_rsvd) cause[EB_RSVD] = 1'b1;
    else if (u_viol)    cause[EB_P] = 1'b1;
    else if (key_deny) begin
      cause[EB_PK] = 1'b1;
      cause[EB_P]  = 1'b1;
    end else            cause[EB_P] = 1'b1;
  end

  always_comb begin
    mods = '0;
    mods[EB_U]  = user_mode;
    mods[EB_W]  = req_w;
    mods[EB_ID] = req_x & (en_nxe | en_smep);
  end

  assign grant    = rights;
  assign fault    = walk_bad | u_viol | rights_deny;
  assign err_code = fault ? (cause | mods) : 6'd0;

  always_comb begin
    if (!fault) assert_nofault_zero_R8: assert (err_code == 6'd0);
    if (walk_bad) assert_walk_nogrant_R1: assert (grant == 3'b000 && fault);
    if (err_code[EB_PK]) assert_pk_with_p_R7: assert (err_code[EB_P]);
    if (req_x) assert_fetch_nokey_R6: assert (!err_code[EB_PK]);
    if (user_mode && !rt_user) assert_user_sup_R2: assert (fault && grant == 3'b000);
    if (grant[1]) assert_write_needs_read_R4: assert (grant[0]);
  end
endmodule

// File: tb/page_rights_check_tb_top.sv
module page_rights_check_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  acc_kind;
  logic        user_mode, walk_np, walk_rsvd, rt_user, rt_rw, rt_nx;
  logic [63:0] leaf_entry;
  logic        en_wp, en_smep, en_smap, en_nxe, en_pke, en_pks;
  logic [31:0] ukey_rights, skey_rights;
  logic [2:0]  grant;
  logic        fault;
  logic [5:0]  err_code;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  page_rights_check dut_i (
    .acc_kind(acc_kind), .user_mode(user_mode), .walk_np(walk_np),
    .walk_rsvd(walk_rsvd), .rt_user(rt_user), .rt_rw(rt_rw), .rt_nx(rt_nx),
    .leaf_entry(leaf_entry), .en_wp(en_wp), .en_smep(en_smep),
    .en_smap(en_smap), .en_nxe(en_nxe), .en_pke(en_pke), .en_pks(en_pks),
    .ukey_rights(ukey_rights), .skey_rights(skey_rights),
    .grant(grant), .fault(fault), .err_code(err_code));

  logic [2:0] e_grant;
  logic       e_fault;
  logic [5:0] e_err;

  task automatic model();
    bit rd, wr, ex, kr, kw, ad, wd, need;
    int k;
    bit [31:0] kreg;
    bit is_st, is_fe;
    is_st = (acc_kind == 2'd1);
    is_fe = (acc_kind == 2'd2);
    k = int'(leaf_entry[62:59]);
    if (rt_user) kreg = en_pke ? ukey_rights : 32'd0;
    else         kreg = en_pks ? skey_rights : 32'd0;
    ad = kreg[2*k];
    wd = kreg[2*k+1];
    rd = !(en_smap && !user_mode && rt_user);
    wr = rd && (rt_rw || (!user_mode && !en_wp));
    ex = !rt_nx && !(!user_mode && en_smep && rt_user);
    kr = !ad;
    kw = !ad && !(wd && (user_mode || en_wp));
    e_err = 6'd0;
    if (walk_np || walk_rsvd) begin
      e_grant = 3'b000;
      e_fault = 1'b1;
      if (!walk_np) e_err = 6'b001000;
    end else if (user_mode && !rt_user) begin
      e_grant = 3'b000;
      e_fault = 1'b1;
      e_err = 6'b000001;
    end else begin
      e_grant = {ex, wr && kw, rd && kr};
      need = is_fe ? e_grant[2] : (is_st ? e_grant[1] : e_grant[0]);
      e_fault = !need;
      if (e_fault) begin
        if ((is_st && !kw) || (!is_st && !is_fe && !kr)) e_err = 6'b100001;
        else e_err = 6'b000001;
      end
    end
    if (e_fault) begin
      if (user_mode) e_err = e_err | 6'b000100;
      if (is_st) e_err = e_err | 6'b000010;
      if (is_fe && (en_nxe || en_smep)) e_err = e_err | 6'b010000;
    end
  endtask

  task automatic compare(input string tag);
    model();
    n_vec++;
    if (grant !== e_grant) begin
      n_bad++;
      $display("FAIL %s R3 R4 R5 R6 grant: got %b expected %b", tag, grant, e_grant);
    end
    if (fault !== e_fault) begin
      n_bad++;
      $display("FAIL %s R1 R2 R7 fault: got %b expected %b", tag, fault, e_fault);
    end
    if (err_code !== e_err) begin
      n_bad++;
      $display("FAIL %s R1 R7 R8 err_code: got %b expected %b", tag, err_code, e_err);
    end
  endtask

  task automatic zero_inputs();
    acc_kind = 2'd0; user_mode = 0; walk_np = 0; walk_rsvd = 0;
    rt_user = 0; rt_rw = 0; rt_nx = 0; leaf_entry = 64'd0;
    en_wp = 0; en_smep = 0; en_smap = 0; en_nxe = 0; en_pke = 0; en_pks = 0;
    ukey_rights = 32'd0; skey_rights = 32'd0;
  endtask

  initial begin
    zero_inputs();
    @(negedge clk);
    #1;
    compare("reset R8");

    // directed: both walker causes, not-present wins (R1)
    walk_np = 1; walk_rsvd = 1; acc_kind = 2'd1; user_mode = 1; rt_user = 1;
    #2; compare("R1 np-over-rsvd");

    // directed: key write-disable ignored for supervisor store with WP off (R6)
    zero_inputs();
    rt_user = 0; rt_rw = 0; acc_kind = 2'd1; en_pks = 1;
    leaf_entry[62:59] = 4'd9; skey_rights = 32'h1 << 19;
    #2; compare("R6 wd-no-wp");

    for (int v = 0; v < (1 << 18); v++) begin
      logic [17:0] b;
      logic [1:0] up, sp;
      int k;
      b = v[17:0];
      acc_kind  = b[1:0];
      user_mode = b[2];  walk_np = b[3];  walk_rsvd = b[4];
      rt_user   = b[5];  rt_rw   = b[6];  rt_nx     = b[7];
      en_wp     = b[8];  en_smep = b[9];  en_smap   = b[10];
      en_nxe    = b[11]; en_pke  = b[12]; en_pks    = b[13];
      up = b[15:14]; sp = b[17:16];
      k = (v * 7 + (v >> 9)) & 15;
      leaf_entry = {64{v[0]}} ^ 64'h5a5a_a5a5_0f0f_f0f0;
      leaf_entry[62:59] = k[3:0];
      ukey_rights = {16{~up}};
      skey_rights = {16{~sp}};
      ukey_rights[2*k +: 2] = up;
      skey_rights[2*k +: 2] = sp;
      #4;
      compare("sweep");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule